// File: doc/BRIEF.md
# Display Window Write Sequencer

This block loads a rectangular window of pixels into a graphics display controller. A host presents start and end coordinates for columns and rows and pulses `start`. The block then produces a tagged byte stream: three setup commands, each followed by its parameter bytes, and then the pixel bytes for every row of the window, taken one for one from a pixel input stream. A downstream serializer takes the tagged bytes and shifts them onto the panel's serial link, which runs in SPI mode 0 at no more than 10 MHz.

Every output byte carries a flag that says whether it is a command (0) or a parameter/pixel byte (1). A three-wire serializer sends this flag as the ninth bit. For four-wire panels the block also drives a separate `dc` pin. That pin is loaded with the same byte and holds its value for as long as that byte is waiting. The block checks a request when `start` arrives and rejects it if a range is inverted or a row would be too long.

Both byte streams use valid/ready handshakes. A byte moves on a clock edge where valid and ready are both high. Once the block raises `out_valid`, it keeps `out_data`, `out_is_data` and `dc` unchanged until `out_ready` takes the byte. `pix_ready` goes high only when the block can take a pixel byte in that same cycle. A pixel source that stalls only delays the output and never corrupts it.

Top module: `win_write_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `out_valid`, `pix_ready` and `dc` are all low.
- R2: An accepted request first emits seven bytes in this fixed order: row-address command, start row, end row, column-address command, start column, end column, memory-write command. The command codes are parameters, with defaults 0x75 (row), 0x15 (column) and 0x5C (memory write).
- R3: After the setup bytes, the block emits (end column − start column + 1) × 2 × (end row − start row + 1) pixel bytes. These are the pixel input bytes, in arrival order and unchanged.
- R4: `out_is_data` is 0 on the three command bytes and 1 on every other emitted byte.
- R5: `mode_4w` is sampled with `start`. In four-wire mode `dc` equals `out_is_data` for every byte presented. In three-wire mode `dc` stays 0.
- R6: While `out_valid` is high and `out_ready` is low, the presented byte and its flags stay unchanged. No byte is lost or duplicated under any pattern of stalls on either stream.
- R7: `done` is a one-cycle pulse in the cycle after the last pixel byte is accepted downstream. `busy` is low from that cycle on.
- R8: A request whose end column is below its start column, or whose end row is below its start row, raises `err` for one cycle after `start`. It emits no byte and leaves the block idle.
- R9: A request whose row length exceeds `MAX_ROW_BYTES` (default 128, that is, more than 64 columns) is rejected as in R8. A row of exactly 128 bytes is accepted.
- R10: A `start` pulse while `busy` is high is ignored: the running transfer finishes unchanged and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled when idle |
| mode_4w | input | 1 | 1 = drive separate `dc` pin; sampled with `start` |
| col_first | input | 8 | Start column |
| col_last | input | 8 | End column (inclusive) |
| row_first | input | 8 | Start row |
| row_last | input | 8 | End row (inclusive) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| pix_valid | input | 1 | Pixel byte available |
| pix_data | input | 8 | Pixel byte |
| pix_ready | output | 1 | Pixel byte taken this cycle when valid |
| out_valid | output | 1 | Tagged byte available |
| out_data | output | 8 | Command, parameter or pixel byte |
| out_is_data | output | 1 | 0 = command, 1 = parameter or pixel |
| out_ready | input | 1 | Downstream takes the byte |
| dc | output | 1 | Four-wire data/command pin, held per byte |

## Verification
The assertions assume that the coordinate and mode inputs matter only in the cycle `start` is sampled while idle. They also assume the pixel source sends bytes only while a transfer is running. They make no assumption about `out_ready`, which may drop at any time. The stimulus changes coordinates only when it pulses `start`. It sizes the pixel source to the exact count for each window and stops the source between transfers. It drives both handshakes with pseudo-random stalls so that stalls on either side, and on both at once, occur across setup, row boundaries and the final byte.

// File: rtl/wws_pkg.sv
package wws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HEAD  = 2'd1,
    ST_PIX   = 2'd2,
    ST_DRAIN = 2'd3
  } wws_state_e;

  localparam int HEAD_LEN = 7;
  localparam int HEAD_W   = $clog2(HEAD_LEN);
endpackage

// File: rtl/wws_req_check.sv
module wws_req_check #(
  parameter int COORD_W       = 8,
  parameter int MAX_ROW_BYTES = 128,
  parameter int RB_W          = 8
) (
  input  logic [COORD_W-1:0] c_first,
  input  logic [COORD_W-1:0] c_last,
  input  logic [COORD_W-1:0] r_first,
  input  logic [COORD_W-1:0] r_last,
  output logic               ok_o,
  output logic [RB_W-1:0]    row_bytes_o,
  output logic [COORD_W-1:0] row_span_o
);
  localparam int SPAN_W = COORD_W + 2;
  localparam logic [SPAN_W-1:0] MAX_B = SPAN_W'(MAX_ROW_BYTES);

  logic [SPAN_W-1:0] nbytes;

  always_comb begin
    nbytes      = ({2'b00, c_last} - {2'b00, c_first} + SPAN_W'(1)) << 1;
    ok_o        = (c_last >= c_first) && (r_last >= r_first) && (nbytes <= MAX_B);
    row_bytes_o = nbytes[RB_W-1:0];
    row_span_o  = r_last - r_first;
  end
endmodule

// File: rtl/wws_walk.sv
module wws_walk #(
  parameter int COORD_W = 8,
  parameter int RB_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               active_i,
  input  logic               step_i,
  input  logic [RB_W-1:0]    row_bytes_i,
  input  logic [COORD_W-1:0] row_span_i,
  output logic               last_o
);
  logic [RB_W-1:0]    byte_q;
  logic [COORD_W-1:0] row_q;
  logic               row_end;

  assign row_end = (byte_q == row_bytes_i - RB_W'(1));
  assign last_o  = row_end && (row_q == row_span_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      row_q  <= '0;
    end else if (clear_i) begin
      byte_q <= '0;
      row_q  <= '0;
    end else if (step_i) begin
      if (row_end) begin
        byte_q <= '0;
        row_q  <= row_q + COORD_W'(1);
      end else begin
        byte_q <= byte_q + RB_W'(1);
      end
    end
  end

  AST_BYTE_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (byte_q < row_bytes_i)) else $error("byte index past row"); // R3
  AST_ROW_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (row_q <= row_span_i)) else $error("row index past window"); // R3
endmodule

// File: rtl/wws_out_stage.sv
module wws_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              ld_flag_i,
  input  logic              ld_dc_i,
  input  logic              out_ready,
  output logic              can_load_o,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_is_data,
  output logic              dc
);
  assign can_load_o = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_is_data <= 1'b0;
      dc          <= 1'b0;
    end else if (load_i) begin
      out_valid   <= 1'b1;
      out_data    <= ld_data_i;
      out_is_data <= ld_flag_i;
      dc          <= ld_dc_i;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_is_data) && $stable(dc))) else $error("byte changed under stall"); // R6
  AST_LOAD_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> can_load_o) else $error("load into occupied stage"); // R6
endmodule

// File: rtl/win_write_seq.sv
module win_write_seq #(
  parameter int         COORD_W       = 8,
  parameter int         MAX_ROW_BYTES = 128,
  parameter logic [7:0] CMD_ROW_ADDR  = 8'h75,
  parameter logic [7:0] CMD_COL_ADDR  = 8'h15,
  parameter logic [7:0] CMD_MEM_WR    = 8'h5C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               mode_4w,
  input  logic [COORD_W-1:0] col_first,
  input  logic [COORD_W-1:0] col_last,
  input  logic [COORD_W-1:0] row_first,
  input  logic [COORD_W-1:0] row_last,
  output logic               busy,
  output logic               done,
  output logic               err,
  input  logic               pix_valid,
  input  logic [7:0]         pix_data,
  output logic               pix_ready,
  output logic               out_valid,
  output logic [7:0]         out_data,
  output logic               out_is_data,
  input  logic               out_ready,
  output logic               dc
);
  import wws_pkg::*;

  localparam int RB_W = $clog2(MAX_ROW_BYTES + 1);
  localparam logic [HEAD_W-1:0] HEAD_LAST = HEAD_W'(HEAD_LEN - 1);

  wws_state_e         state;
  logic [HEAD_W-1:0]  head_idx;
  logic [COORD_W-1:0] c0_q, c1_q, r0_q, r1_q;
  logic               m4_q;
  logic [RB_W-1:0]    rb_q;
  logic [COORD_W-1:0] rs_q;

  logic               req_ok;
  logic [RB_W-1:0]    req_rb;
  logic [COORD_W-1:0] req_rs;
  logic               can_load, load, last_pix;
  logic               gen_v, gen_f;
  logic [7:0]         gen_d;

  wws_req_check #(.COORD_W(COORD_W), .MAX_ROW_BYTES(MAX_ROW_BYTES), .RB_W(RB_W)) u_chk (
    .c_first(col_first), .c_last(col_last), .r_first(row_first), .r_last(row_last),
    .ok_o(req_ok), .row_bytes_o(req_rb), .row_span_o(req_rs)
  );

  always_comb begin
    gen_v = 1'b0;
    gen_f = 1'b0;
    gen_d = '0;
    unique case (state)
      ST_HEAD: begin
        gen_v = 1'b1;
        case (head_idx)
          3'd0:    begin gen_f = 1'b0; gen_d = CMD_ROW_ADDR; end
          3'd1:    begin gen_f = 1'b1; gen_d = 8'(r0_q); end
          3'd2:    begin gen_f = 1'b1; gen_d = 8'(r1_q); end
          3'd3:    begin gen_f = 1'b0; gen_d = CMD_COL_ADDR; end
          3'd4:    begin gen_f = 1'b1; gen_d = 8'(c0_q); end
          3'd5:    begin gen_f = 1'b1; gen_d = 8'(c1_q); end
          default: begin gen_f = 1'b0; gen_d = CMD_MEM_WR; end
        endcase
      end
      ST_PIX: begin
        gen_v = pix_valid;
        gen_f = 1'b1;
        gen_d = pix_data;
      end
      default: ;
    endcase
  end

  assign load      = gen_v && can_load;
  assign pix_ready = (state == ST_PIX) && can_load;
  assign busy      = (state != ST_IDLE);

  wws_walk #(.COORD_W(COORD_W), .RB_W(RB_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .clear_i(state == ST_IDLE), .active_i(state == ST_PIX),
    .step_i(load && (state == ST_PIX)),
    .row_bytes_i(rb_q), .row_span_i(rs_q), .last_o(last_pix)
  );

  wws_out_stage #(.DATA_W(8)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load_i(load), .ld_data_i(gen_d), .ld_flag_i(gen_f), .ld_dc_i(m4_q & gen_f),
    .out_ready(out_ready), .can_load_o(can_load),
    .out_valid(out_valid), .out_data(out_data), .out_is_data(out_is_data), .dc(dc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      head_idx <= '0;
      c0_q     <= '0;
      c1_q     <= '0;
      r0_q     <= '0;
      r1_q     <= '0;
      m4_q     <= 1'b0;
      rb_q     <= '0;
      rs_q     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          if (req_ok) begin
            c0_q     <= col_first;
            c1_q     <= col_last;
            r0_q     <= row_first;
            r1_q     <= row_last;
            m4_q     <= mode_4w;
            rb_q     <= req_rb;
            rs_q     <= req_rs;
            head_idx <= '0;
            state    <= ST_HEAD;
          end else begin
            err <= 1'b1;
          end
        end
        ST_HEAD: if (load) begin
          if (head_idx == HEAD_LAST) state <= ST_PIX;
          else head_idx <= head_idx + HEAD_W'(1);
        end
        ST_PIX: if (load && last_pix) state <= ST_DRAIN;
        ST_DRAIN: if (out_ready) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !out_valid)) else $error("reject while active"); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !out_valid)) else $error("done while active"); // R7
  AST_DC_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && m4_q) |-> (dc == out_is_data)) else $error("dc mismatch"); // R5
  AST_DC_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !m4_q) |-> !dc) else $error("dc driven in 3-wire"); // R5
  AST_PIX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> busy) else $error("pixel taken while idle"); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(c0_q) && $stable(c1_q) && $stable(r0_q) && $stable(r1_q) &&
      $stable(m4_q))) else $error("request changed mid-transfer"); // R10
endmodule

// File: tb/sim_win_write_seq.sv
`timescale 1ns/1ps
module sim_win_write_seq;
  localparam logic [7:0] K_ROW = 8'h75;
  localparam logic [7:0] K_COL = 8'h15;
  localparam logic [7:0] K_MEM = 8'h5C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, mode_4w = 1'b0;
  logic [7:0] col_first = '0, col_last = '0, row_first = '0, row_last = '0;
  logic       busy, done, err;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_data = '0;
  logic       pix_ready;
  logic       out_valid, out_is_data, dc;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, done_cnt = 0, done_cyc = 0, last_acc = 0, pix_taken = 0;
  int pix_snap = 0, pix_lim = 0;
  logic [7:0] pix_base = '0;
  bit   stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic [8:0] got_q[$];
  logic       dc_q[$];

  always #2.5 clk = ~clk;

  win_write_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_4w(mode_4w),
    .col_first(col_first), .col_last(col_last), .row_first(row_first), .row_last(row_last),
    .busy(busy), .done(done), .err(err),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .out_valid(out_valid), .out_data(out_data), .out_is_data(out_is_data),
    .out_ready(out_ready), .dc(dc)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pix_valid && pix_ready) pix_taken <= pix_taken + 1;
    if (out_valid && out_ready) begin
      got_q.push_back({out_is_data, out_data});
      dc_q.push_back(dc);
      last_acc <= cyc;
    end
    if (done) begin
      done_cnt <= done_cnt + 1;
      done_cyc <= cyc;
    end
  end

  initial forever begin
    @(negedge clk);
    pix_valid = (pix_taken < pix_lim) && (!stall_en || lfsr[1]);
    pix_data  = pix_base + 8'(pix_taken - pix_snap);
    out_ready = !stall_en || lfsr[0] || lfsr[5];
    lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done && !err, "R1", "busy/done/err", {busy, done, err}, 0);
    chk(!out_valid && !pix_ready && !dc, "R1", "valid/ready/dc", {out_valid, pix_ready, dc}, 0);
  endtask

  task automatic run_win(string req, int c0, int c1, int r0, int r1, bit m4, bit stall, bit inject);
    int nb, gi0, d0, tmo;
    logic [8:0] exp_q[$];
    nb  = (c1 - c0 + 1) * 2 * (r1 - r0 + 1);
    gi0 = got_q.size();
    d0  = done_cnt;
    exp_q.push_back({1'b0, K_ROW}); exp_q.push_back({1'b1, 8'(r0)}); exp_q.push_back({1'b1, 8'(r1)});
    exp_q.push_back({1'b0, K_COL}); exp_q.push_back({1'b1, 8'(c0)}); exp_q.push_back({1'b1, 8'(c1)});
    exp_q.push_back({1'b0, K_MEM});
    @(negedge clk);
    pix_base = 8'(c0 * 7 + r0 + 3);
    pix_snap = pix_taken;
    pix_lim  = pix_taken + nb;
    stall_en = stall;
    for (int k = 0; k < nb; k++) exp_q.push_back({1'b1, pix_base + 8'(k)});
    col_first = 8'(c0); col_last = 8'(c1); row_first = 8'(r0); row_last = 8'(r1);
    mode_4w = m4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (12) @(negedge clk);
      chk(busy, "R10", "busy before injected start", busy, 1);
      col_first = 8'd1; col_last = 8'd2; row_first = 8'd3; row_last = 8'd3; mode_4w = !m4;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    tmo = 0;
    while (done_cnt == d0 && tmo < 20000) begin
      @(negedge clk);
      tmo++;
    end
    repeat (4) @(negedge clk);
    chk(got_q.size() - gi0 == exp_q.size(), "R3", {req, " byte count"}, got_q.size() - gi0, exp_q.size());
    for (int i = 0; i < exp_q.size() && gi0 + i < got_q.size(); i++) begin
      string r;
      r = (i < 7) ? "R2" : "R3";
      chk(got_q[gi0+i][7:0] == exp_q[i][7:0], r, {req, " byte value"}, got_q[gi0+i][7:0], exp_q[i][7:0]);
      chk(got_q[gi0+i][8] == exp_q[i][8], "R4", {req, " tag"}, got_q[gi0+i][8], exp_q[i][8]);
      chk(dc_q[gi0+i] == (m4 & exp_q[i][8]), "R5", {req, " dc"}, dc_q[gi0+i], m4 & exp_q[i][8]);
    end
    chk(done_cnt - d0 == 1, inject ? "R10" : "R7", {req, " done pulses"}, done_cnt - d0, 1);
    chk(done_cyc == last_acc + 1, "R7", {req, " done timing"}, done_cyc - last_acc, 1);
    chk(!busy && !out_valid, "R7", {req, " idle after done"}, {busy, out_valid}, 0);
    stall_en = 1'b0;
    pix_lim  = pix_taken;
  endtask

  task automatic t_reject(string req, int c0, int c1, int r0, int r1);
    int gi0, d0;
    gi0 = got_q.size();
    d0  = done_cnt;
    @(negedge clk);
    col_first = 8'(c0); col_last = 8'(c1); row_first = 8'(r0); row_last = 8'(r1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err && !busy, req, "err raised, idle", {err, busy}, 2);
    @(negedge clk);
    chk(!err, req, "err one cycle", err, 0);
    repeat (20) @(negedge clk);
    chk(got_q.size() == gi0 && done_cnt == d0 && !busy, req, "no bytes emitted", got_q.size() - gi0, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    run_win("R2 single pixel 4-wire", 7, 7, 9, 9, 1'b1, 1'b0, 1'b0);
    run_win("R3 3x4 window 3-wire", 2, 5, 10, 12, 1'b0, 1'b0, 1'b0);
    run_win("R6 stalled window 4-wire", 2, 5, 10, 12, 1'b1, 1'b1, 1'b0);
    run_win("R6 tall column stalled", 10, 10, 0, 19, 1'b0, 1'b1, 1'b0);
    run_win("R9 128-byte row", 0, 63, 4, 5, 1'b1, 1'b1, 1'b0);
    run_win("R10 start while busy", 3, 6, 1, 2, 1'b1, 1'b0, 1'b1);
    t_reject("R8", 5, 4, 0, 0);
    t_reject("R8", 0, 3, 9, 8);
    t_reject("R9", 0, 64, 0, 0);
    run_win("R7 after rejects", 20, 21, 30, 30, 1'b0, 1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule